// File: doc/BRIEF.md
# SMBus Block Transfer Buffer

This block is the block-transfer data path of an SMBus host controller. It holds a buffer of `DEPTH` bytes that software fills or drains through a single data-port register. An internal index steps forward on every access to that port. A byte-count register tells the hardware how many bytes to move. The buffer path works only when the buffer-mode bit in the auxiliary control register is set. The same register also carries a checksum-enable bit, which is passed to the bus engine.

Software starts a block transfer by writing the block code, together with the go bit, to the control register. On a write transfer, the block first hands the count byte and then the buffered bytes to the bit-level bus engine, one byte at a time over a valid/ready handshake. On a read transfer, the engine returns a count byte and then that many data bytes. The count is stored in the count register and the data is stored from entry 0 upward. At the end the index is rewound, so software reads the data starting at entry 0. A count outside 1..`DEPTH`, whether written by software or received from the target, is flagged in the auxiliary status register.

Top module: `smbb_buffer`

## Requirements
- R1: After reset, every register (control 2, target 4, count 5, aux status 12, aux control 13) reads 0, and xfer_start, xfer_end, tx_valid and chk_en are low.
- R2: Aux control (offset 13) keeps only bit 1 (buffer mode) and bit 0 (checksum enable, also driven on chk_en). It reads back exactly those two bits as written, and bits 7:2 read 0.
- R3: Any read of the control register (offset 2) rewinds the buffer index to entry 0. The control register reads back the last written value with bit 6 cleared.
- R4: While idle, each read or write of the data port (offset 7) advances the index by one. A read returns the entry at the index, and a write stores into it.
- R5: The index stops at DEPTH. Port writes beyond the last entry are dropped, and reads return the last entry.
- R6: A control write with bit 6 set and bits 5:2 = 0101 (code 0x14), with buffer mode on, target bit 0 = 0 and a valid count, pulses xfer_start. The block then sends the count byte followed by entries 0..count-1 on tx_data. A byte is held stable while tx_ready is low. xfer_end pulses one cycle after the last byte is accepted.
- R7: With buffer mode off, or with a control code other than 0101, a write with bit 6 set starts no transfer.
- R8: A write-direction start with count 0 or above DEPTH starts no transfer and sets aux status bit 1.
- R9: With target bit 0 = 1, the first received byte is loaded into the count register and the next count bytes fill entries 0 upward. Then xfer_end pulses and the index is back at entry 0.
- R10: A received count of 0 or above DEPTH is still loaded into the count register, sets aux status bit 1 and ends the transfer with xfer_end. Writing 1 to status bit 1 clears it.
- R11: During a transfer, aux status bit 0 reads 1. Data-port accesses, and writes to control, target, count and aux control, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| chk_en | output | 1 | Checksum enable to bus engine |
| xfer_addr | output | DW | Target address byte, bit 0 = read direction |
| xfer_start | output | 1 | One-cycle pulse, transfer started |
| xfer_end | output | 1 | One-cycle pulse, transfer finished |
| tx_data | output | DW | Byte offered to the bus engine |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Bus engine takes tx_data |
| rx_data | input | DW | Byte received from the target |
| rx_valid | input | 1 | rx_data is valid |

## Verification
The bench sweeps every transfer length from 1 to 32 in both directions, with and without handshake stalls. An off-by-one in the end condition would send or store one byte too many or too few, and a missing stall hold would drop bytes. It drives the index past the last entry. A design that wraps would overwrite entry 0, and one that does not saturate reads would return stale data. It feeds out-of-range counts from software and from the target, touches the data port and the count in mid-transfer, and sweeps all aux control values. A design that leaks these would start a bad transfer, corrupt the buffer or keep stray control bits.

// File: rtl/smbb_pkg.sv
// Shared constants and types for the SMBus block buffer.
// Assumes register offsets are 4 bits and the data width is at least 8.
package smbb_pkg;
    localparam logic [3:0] OFS_CTRL  = 4'd2;
    localparam logic [3:0] OFS_TADDR = 4'd4;
    localparam logic [3:0] OFS_COUNT = 4'd5;
    localparam logic [3:0] OFS_PORT  = 4'd7;
    localparam logic [3:0] OFS_XSTAT = 4'd12;
    localparam logic [3:0] OFS_XCTRL = 4'd13;

    localparam logic [3:0] BLOCK_CODE = 4'b0101;
    localparam int unsigned GO_BIT    = 6;
    localparam int unsigned BUF_BIT   = 1;
    localparam int unsigned CHK_BIT   = 0;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_TXCNT = 3'd1,
        SQ_TXDAT = 3'd2,
        SQ_RXCNT = 3'd3,
        SQ_RXDAT = 3'd4
    } seq_state_t;
endpackage

// File: rtl/smbb_regs.sv
// Register file and start decode for the block buffer.
// Assumes: single-cycle strobes; writes other than the status clear are
// blocked while a transfer runs; read data is combinational.
module smbb_regs
    import smbb_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy,
    input  logic [DW-1:0] port_rdata,
    input  logic          cnt_we,
    input  logic [DW-1:0] cnt_wdata,
    input  logic          seq_err,
    output logic [DW-1:0] count_q,
    output logic [DW-1:0] taddr_q,
    output logic          chk_en,
    output logic          go,
    output logic          go_rd,
    output logic          port_wr,
    output logic          port_rd,
    output logic          ctrl_rd
);
    localparam logic [DW-1:0] MAXCNT = DW'(DEPTH);

    logic [DW-1:0] ctrl_q;
    logic [1:0]    xctrl_q;
    logic          err_q;
    logic          wr_ok;
    logic          go_req;
    logic          cnt_ok;
    logic          wcnt_err;

    // Decode strobes and the transfer start request.
    always_comb begin
        wr_ok    = reg_wr && !busy;
        go_req   = wr_ok && (reg_addr == OFS_CTRL) && reg_wdata[GO_BIT]
                   && (reg_wdata[5:2] == BLOCK_CODE) && xctrl_q[BUF_BIT];
        cnt_ok   = (count_q != '0) && (count_q <= MAXCNT);
        go_rd    = taddr_q[0];
        go       = go_req && (taddr_q[0] || cnt_ok);
        wcnt_err = go_req && !taddr_q[0] && !cnt_ok;
        port_wr  = wr_ok && (reg_addr == OFS_PORT);
        port_rd  = reg_rd && !busy && (reg_addr == OFS_PORT);
        ctrl_rd  = reg_rd && (reg_addr == OFS_CTRL);
        chk_en   = xctrl_q[CHK_BIT];
    end

    // Control byte storage; the go bit never sticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ok && reg_addr == OFS_CTRL) begin
            ctrl_q         <= reg_wdata;
            ctrl_q[GO_BIT] <= 1'b0;
        end
    end

    // Target address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taddr_q <= '0;
        end else if (wr_ok && reg_addr == OFS_TADDR) begin
            taddr_q <= reg_wdata;
        end
    end

    // Byte count: the received count has priority over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_we) begin
            count_q <= cnt_wdata;
        end else if (wr_ok && reg_addr == OFS_COUNT) begin
            count_q <= reg_wdata;
        end
    end

    // Auxiliary control: buffer mode and checksum enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xctrl_q <= '0;
        end else if (wr_ok && reg_addr == OFS_XCTRL) begin
            xctrl_q <= reg_wdata[1:0];
        end
    end

    // Count error flag: set wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (seq_err || wcnt_err) begin
            err_q <= 1'b1;
        end else if (reg_wr && reg_addr == OFS_XSTAT && reg_wdata[1]) begin
            err_q <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL:  reg_rdata = ctrl_q;
            OFS_TADDR: reg_rdata = taddr_q;
            OFS_COUNT: reg_rdata = count_q;
            OFS_PORT:  reg_rdata = port_rdata;
            OFS_XSTAT: reg_rdata = {{(DW-2){1'b0}}, err_q, busy};
            OFS_XCTRL: reg_rdata = {{(DW-2){1'b0}}, xctrl_q};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/smbb_index.sv
// Software-side buffer index. It saturates at DEPTH, meaning past the last
// entry. Assumes a clear and an advance never need to be applied together;
// the clear wins.
module smbb_index #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned IW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] idx_q
);
    localparam logic [IW-1:0] LIMIT = IW'(DEPTH);

    // Rewind on clear; step on access until the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (adv && idx_q != LIMIT) begin
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/smbb_store.sv
// Byte store of DEPTH entries: one write port and two combinational read
// ports (one for software, one for the sequencer). Entries reset to zero.
module smbb_store #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 32,
    parameter int unsigned SW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] ra_sw,
    output logic [DW-1:0] rd_sw,
    input  logic [SW-1:0] ra_seq,
    output logic [DW-1:0] rd_seq
);
    logic [DW-1:0] cells [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [DW-1:0] cell_q;
        // Load this entry when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (we && waddr == SW'(e)) begin
                cell_q <= wdata;
            end
        end
        assign cells[e] = cell_q;
    end

    assign rd_sw  = cells[ra_sw];
    assign rd_seq = cells[ra_seq];
endmodule

// File: rtl/smbb_seq.sv
// Transfer sequencer. On a write it sends the count byte, then the entries.
// On a read it takes the count byte, then stores the entries.
// Assumes the bus engine follows valid/ready on tx and presents one byte
// per rx_valid cycle.
module smbb_seq
    import smbb_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 32,
    parameter int unsigned SW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_rd,
    input  logic [DW-1:0] count_q,
    input  logic [DW-1:0] buf_rdata,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          busy,
    output logic          xfer_start,
    output logic          xfer_end,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic [SW-1:0] ptr,
    output logic          rx_we,
    output logic          cnt_we,
    output logic          err_set,
    output logic          idx_clr
);
    localparam logic [DW-1:0] MAXCNT = DW'(DEPTH);

    seq_state_t state;
    logic       last;
    logic       rx_ok;

    // Per-cycle decode of the current step.
    always_comb begin
        busy     = (state != SQ_IDLE);
        last     = (DW'(ptr) + 1'b1) == count_q;
        rx_ok    = (rx_data != '0) && (rx_data <= MAXCNT);
        tx_valid = (state == SQ_TXCNT) || (state == SQ_TXDAT);
        tx_data  = (state == SQ_TXCNT) ? count_q : buf_rdata;
        rx_we    = (state == SQ_RXDAT) && rx_valid;
        cnt_we   = (state == SQ_RXCNT) && rx_valid;
        err_set  = cnt_we && !rx_ok;
        idx_clr  = err_set || (rx_we && last);
    end

    // State, entry pointer and the start/end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            ptr        <= '0;
            xfer_start <= 1'b0;
            xfer_end   <= 1'b0;
        end else begin
            xfer_start <= 1'b0;
            xfer_end   <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state      <= start_rd ? SQ_RXCNT : SQ_TXCNT;
                        ptr        <= '0;
                        xfer_start <= 1'b1;
                    end
                end
                SQ_TXCNT: begin
                    if (tx_ready) state <= SQ_TXDAT;
                end
                SQ_TXDAT: begin
                    if (tx_ready) begin
                        if (last) begin
                            state    <= SQ_IDLE;
                            xfer_end <= 1'b1;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                SQ_RXCNT: begin
                    if (rx_valid) begin
                        if (rx_ok) begin
                            state <= SQ_RXDAT;
                        end else begin
                            state    <= SQ_IDLE;
                            xfer_end <= 1'b1;
                        end
                    end
                end
                SQ_RXDAT: begin
                    if (rx_valid) begin
                        if (last) begin
                            state    <= SQ_IDLE;
                            xfer_end <= 1'b1;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smbb_buffer.sv
// Top of the SMBus block buffer. It ties together the register file, the
// software index, the byte store and the transfer sequencer, and it routes
// the store's single write port between software and received data.
// Assumes software and sequencer writes never coincide (busy gating).
module smbb_buffer
    import smbb_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          chk_en,
    output logic [DW-1:0] xfer_addr,
    output logic          xfer_start,
    output logic          xfer_end,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_valid
);
    localparam int unsigned IW = $clog2(DEPTH + 1);
    localparam int unsigned SW = $clog2(DEPTH);

    logic [DW-1:0] count_q;
    logic [DW-1:0] port_rdata;
    logic [DW-1:0] seq_rdata;
    logic [IW-1:0] idx_q;
    logic [SW-1:0] slot;
    logic [SW-1:0] seq_ptr;
    logic [SW-1:0] st_waddr;
    logic [DW-1:0] st_wdata;
    logic          busy, go, go_rd, port_wr, port_rd, ctrl_rd;
    logic          cnt_we, seq_err, rx_we, seq_idx_clr;
    logic          idx_full, sw_we, st_we;

    // Route the store write port and derive the software slot.
    always_comb begin
        idx_full = (idx_q == IW'(DEPTH));
        slot     = idx_full ? SW'(DEPTH - 1) : idx_q[SW-1:0];
        sw_we    = port_wr && !idx_full;
        st_we    = sw_we || rx_we;
        st_waddr = rx_we ? seq_ptr : slot;
        st_wdata = rx_we ? rx_data : reg_wdata;
    end

    smbb_regs #(.DW(DW), .DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .port_rdata(port_rdata),
        .cnt_we(cnt_we), .cnt_wdata(rx_data), .seq_err(seq_err),
        .count_q(count_q), .taddr_q(xfer_addr), .chk_en(chk_en),
        .go(go), .go_rd(go_rd),
        .port_wr(port_wr), .port_rd(port_rd), .ctrl_rd(ctrl_rd)
    );

    smbb_index #(.DEPTH(DEPTH), .IW(IW)) u_index (
        .clk(clk), .rst_n(rst_n),
        .clr(ctrl_rd || seq_idx_clr),
        .adv(port_wr || port_rd),
        .idx_q(idx_q)
    );

    smbb_store #(.DW(DW), .DEPTH(DEPTH), .SW(SW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
        .ra_sw(slot), .rd_sw(port_rdata),
        .ra_seq(seq_ptr), .rd_seq(seq_rdata)
    );

    smbb_seq #(.DW(DW), .DEPTH(DEPTH), .SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(go), .start_rd(go_rd), .count_q(count_q),
        .buf_rdata(seq_rdata), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .busy(busy), .xfer_start(xfer_start), .xfer_end(xfer_end),
        .tx_valid(tx_valid), .tx_data(tx_data), .ptr(seq_ptr),
        .rx_we(rx_we), .cnt_we(cnt_we), .err_set(seq_err),
        .idx_clr(seq_idx_clr)
    );
endmodule

// File: rtl/smbb_buffer_chk.sv
// Property checker for smbb_buffer, bound to every instance of the top.
// Looks at the ports plus the busy flag and the software index.
module smbb_buffer_chk
    import smbb_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 32,
    parameter int unsigned IW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [DW-1:0] reg_rdata,
    input logic          xfer_start,
    input logic          xfer_end,
    input logic [DW-1:0] tx_data,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          rx_valid,
    input logic          busy,
    input logic [IW-1:0] idx
);
    // R2
    aux_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_XCTRL) |-> (reg_rdata[DW-1:2] == '0));

    // R3
    ctrl_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_CTRL) |=> (idx == '0));

    // R4
    port_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_PORT && !busy && idx < IW'(DEPTH))
        |=> (idx == IW'($past(idx) + 1'b1)));

    // R5
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && reg_addr == OFS_PORT && idx == IW'(DEPTH))
        |=> (idx == IW'(DEPTH)));

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> busy);

    // R10
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |-> !busy);

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_start, xfer_end}));

    // R11
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (reg_wr || reg_rd) && reg_addr == OFS_PORT && !rx_valid)
        |=> $stable(idx));
endmodule

bind smbb_buffer smbb_buffer_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .xfer_start(xfer_start),
    .xfer_end(xfer_end), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .busy(busy), .idx(idx_q)
);

// File: tb/smbb_buffer_test.sv
module smbb_buffer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, xfer_addr, tx_data;
    logic       chk_en, xfer_start, xfer_end, tx_valid;
    logic       tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    int checks = 0, fails = 0;

    localparam logic [3:0] A_CTRL = 4'd2, A_TADDR = 4'd4, A_COUNT = 4'd5;
    localparam logic [3:0] A_PORT = 4'd7, A_XSTAT = 4'd12, A_XCTRL = 4'd13;

    smbb_buffer uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chk_en(chk_en), .xfer_addr(xfer_addr), .xfer_start(xfer_start),
        .xfer_end(xfer_end), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input int i, input int s);
        return 8'((i * 7 + s * 13 + 3) & 255);
    endfunction

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic fill(input int n, input int s);
        logic [7:0] t;
        rd(A_CTRL, t);
        for (int i = 0; i < n; i++) wr(A_PORT, pat(i, s));
    endtask

    // R6: block write of n bytes, optional stalls on tx_ready
    task automatic do_tx(input int n, input bit bp);
        int got = 0, bad = 0;
        logic [7:0] ex;
        fill(n, n);
        wr(A_COUNT, 8'(n)); wr(A_TADDR, 8'hB4); wr(A_CTRL, 8'h54);
        chk("R6 start pulse", int'(xfer_start), 1);
        for (int cyc = 0; cyc < 300; cyc++) begin
            @(negedge clk);
            if (xfer_end) break;
            tx_ready = bp ? (cyc % 2 == 1) : 1'b1;
            if (tx_valid && tx_ready) begin
                ex = (got == 0) ? 8'(n) : pat(got - 1, n);
                if (tx_data != ex) bad++;
                got++;
            end
        end
        tx_ready = 1'b0;
        chk("R6 bytes sent", got, n + 1);
        chk("R6 byte values", bad, 0);
        chk("R6 target addr", int'(xfer_addr), 8'hB4);
    endtask

    // R9: block read of n bytes, optional gaps on rx_valid
    task automatic do_rx(input int n, input bit gaps);
        int sent = 0, bad = 0;
        bit ended = 0;
        logic [7:0] t;
        wr(A_TADDR, 8'hB5); wr(A_CTRL, 8'h54);
        for (int cyc = 0; cyc < 300; cyc++) begin
            @(negedge clk);
            if (xfer_end) begin ended = 1; break; end
            if (sent <= n && !(gaps && cyc % 3 == 1)) begin
                rx_valid = 1'b1;
                rx_data = (sent == 0) ? 8'(n) : pat(sent - 1, n + 50);
                sent++;
            end else rx_valid = 1'b0;
        end
        rx_valid = 1'b0;
        chk("R9 end pulse", int'(ended), 1);
        rd(A_COUNT, t); chk("R9 count loaded", int'(t), n);
        rd(A_XSTAT, t); chk("R9 status clean", int'(t), 0);
        for (int i = 0; i < n; i++) begin
            rd(A_PORT, t);
            if (t != pat(i, n + 50)) bad++;
        end
        chk("R9 stored data from entry 0", bad, 0);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] t;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        rd(A_CTRL, t);  chk("R1 ctrl", int'(t), 0);
        rd(A_TADDR, t); chk("R1 target", int'(t), 0);
        rd(A_COUNT, t); chk("R1 count", int'(t), 0);
        rd(A_XSTAT, t); chk("R1 aux status", int'(t), 0);
        rd(A_XCTRL, t); chk("R1 aux ctrl", int'(t), 0);
        chk("R1 outputs idle", int'({xfer_start, xfer_end, tx_valid, chk_en}), 0);

        // R2: aux control sweep
        for (int v = 0; v < 256; v++) begin
            wr(A_XCTRL, 8'(v));
            rd(A_XCTRL, t);
            chk("R2 aux readback", int'(t), v & 3);
            chk("R2 chk_en", int'(chk_en), v & 1);
        end
        wr(A_XCTRL, 8'h02);

        // R4 and R3: full buffer write then read back from entry 0
        fill(32, 1);
        rd(A_CTRL, t);
        for (int i = 0; i < 32; i++) begin
            rd(A_PORT, t); chk("R4 port readback", int'(t), int'(pat(i, 1)));
        end
        // R5: saturation at the end of the buffer
        fill(34, 9);
        rd(A_CTRL, t);
        for (int i = 0; i < 34; i++) begin
            rd(A_PORT, t);
            chk("R5 saturated index", int'(t), int'(pat(i < 31 ? i : 31, 9)));
        end
        // R3: mid-buffer rewind
        fill(5, 5);
        rd(A_CTRL, t);
        rd(A_PORT, t); chk("R3 rewind to entry 0", int'(t), int'(pat(0, 5)));

        // R7: no start without buffer mode or with another code
        wr(A_COUNT, 8'd4); wr(A_TADDR, 8'hB4);
        wr(A_XCTRL, 8'h00); wr(A_CTRL, 8'h54);
        chk("R7 mode off no start", int'(xfer_start), 0);
        rd(A_XSTAT, t); chk("R7 mode off idle", int'(t), 0);
        wr(A_XCTRL, 8'h02); wr(A_CTRL, 8'h4C);
        chk("R7 other code no start", int'(xfer_start), 0);
        rd(A_CTRL, t); chk("R3 ctrl stored without go", int'(t), 8'h0C);

        // R8: bad software counts
        foreach (t[b]) begin end
        for (int k = 0; k < 2; k++) begin
            wr(A_COUNT, k == 0 ? 8'd0 : 8'd33); wr(A_CTRL, 8'h54);
            chk("R8 no start", int'(xfer_start), 0);
            rd(A_XSTAT, t); chk("R8 error set", int'(t), 2);
            wr(A_XSTAT, 8'h02);
        end

        // R6: write sweep over all lengths
        for (int n = 1; n <= 32; n++) do_tx(n, n % 2 == 0);

        // R11: accesses during a transfer are ignored
        begin
            int got = 0;
            fill(4, 4);
            wr(A_COUNT, 8'd4); wr(A_TADDR, 8'hB4); wr(A_CTRL, 8'h54);
            for (int cyc = 0; cyc < 300; cyc++) begin
                @(negedge clk);
                if (xfer_end) break;
                tx_ready = (cyc % 2 == 1);
                if (tx_valid && tx_ready) got++;
                reg_wr = (cyc < 2);
                reg_addr = (cyc == 0) ? A_PORT : (cyc == 1) ? A_COUNT : A_XSTAT;
                reg_wdata = (cyc == 0) ? 8'hEE : 8'h09;
                if (cyc == 2) begin
                    #1 chk("R11 busy flag", int'(reg_rdata), 1);
                end
            end
            reg_wr = 1'b0; tx_ready = 1'b0;
            chk("R11 count unchanged in flight", got, 5);
            wr(A_PORT, 8'h77);
            rd(A_CTRL, t);
            for (int i = 0; i < 5; i++) begin
                rd(A_PORT, t);
                chk("R11 buffer and index untouched", int'(t),
                    i < 4 ? int'(pat(i, 4)) : 8'h77);
            end
            rd(A_COUNT, t); chk("R11 count register kept", int'(t), 4);
        end

        // R9: read sweep over all lengths
        for (int n = 1; n <= 32; n++) do_rx(n, n % 2 == 1);

        // R10: bad counts from the target
        for (int k = 0; k < 3; k++) begin
            logic [7:0] c;
            c = (k == 0) ? 8'd0 : (k == 1) ? 8'd33 : 8'd255;
            wr(A_TADDR, 8'hB5); wr(A_CTRL, 8'h54);
            @(negedge clk); rx_valid = 1'b1; rx_data = c;
            @(negedge clk); rx_valid = 1'b0;
            chk("R10 end pulse", int'(xfer_end), 1);
            rd(A_COUNT, t); chk("R10 count loaded", int'(t), int'(c));
            rd(A_XSTAT, t); chk("R10 error set", int'(t), 2);
            wr(A_XSTAT, 8'h02);
            rd(A_XSTAT, t); chk("R10 error cleared", int'(t), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule